// File: doc/BRIEF.md
# Programmable two-phase clock divider

This block divides one input clock into two slower phases that share a programmable prescaler. An 8-bit prescale code sets a base ratio n from 2 to 256. Each phase then applies its own power-of-two post-divide chosen by a 2-bit code. Phase 1 offers ratios of 1, 2, 4 or 8, up to 2048 overall. Phase 2 offers 2, 4, 8 or 16, up to 4096 overall. Each phase leaves the block as a true output and a complement output. All of them are registered on the input clock. An undivided copy of the input clock is also brought out.

The prescaler is a two-state machine. In `ST_COUNT` its counter climbs from 0. The transition `COUNT_TO_LAST` is taken when the counter reaches n-2. The machine then spends exactly one input cycle in `ST_LAST`, which is the wrap cycle, and returns to `ST_COUNT` with the counter cleared through `LAST_TO_COUNT`. A synchronous reset forces `ST_COUNT` through `ANY_TO_COUNT`. Both post-dividers read bits of one shared binary counter that advances once per wrap, so the two phases switch in the same input cycle. New codes are captured only at a wrap, and at reset.

Phase 1 code 00 is different from all other settings. It produces a pulse that is high for one input period once per prescaler cycle, where every other setting gives a square wave.

Top module: `dual_phase_divider`

## Requirements
- R1: The prescale code k sets the base ratio n as follows: k=0 gives n=256, k=1 gives n=2, and any other k gives n=k.
- R2: Phase 1 code 00, 01, 10 or 11 gives an output period of n, 2n, 4n or 8n input cycles.
- R3: With phase 1 code 00, the phase 1 output is high for exactly one input cycle in each period.
- R4: Phase 2 code 00, 01, 10 or 11 gives an output period of 2n, 4n, 8n or 16n input cycles.
- R5: Every setting other than phase 1 code 00 gives a high time of exactly half the period, and this holds for odd n as well.
- R6: Each complement output is always the inverse of its true output.
- R7: When phase 1 is not at code 00, both phases change only in the cycle that follows a prescaler wrap. With phase 1 code k+1 and phase 2 code k, the two outputs are identical.
- R8: While reset is high, and in the first cycle after it, both true outputs are low and both complements are high.
- R9: A prescale code change made during a prescaler cycle leaves that cycle at the old length. The new length applies from the next cycle onward.
- R10: The pass-through output follows the input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| pre_code | input | 8 | Prescale code (R1 mapping) |
| ph1_code | input | 2 | Phase 1 post-divide code |
| ph2_code | input | 2 | Phase 2 post-divide code |
| ph1_o | output | 1 | Phase 1 true output |
| ph1_n_o | output | 1 | Phase 1 complement output |
| ph2_o | output | 1 | Phase 2 true output |
| ph2_n_o | output | 1 | Phase 2 complement output |
| thru_o | output | 1 | Undivided copy of the input clock |

## Verification
A wrong prescaler count or state shows up at the outputs within one prescaler cycle, as a period other than a multiple of n. In pulse mode, a wrong count stretches or shifts the next pulse. A fault in the shared post counter or in the selection of a phase bit shows up as a wrong period or a duty cycle other than half within one output period. A fault in the complement registers shows up in the very next cycle as equal true and complement levels. A capture of settings outside the wrap cycle shows up as the wrong spacing of the first pulse after a code change.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_LAST  = 1'b1
    } pre_state_e;
endpackage

// File: rtl/dpd_prescaler.sv
module dpd_prescaler
    import dpd_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] code_i,
    output logic             wrap_o,
    output logic [PRE_W-1:0] cnt_o,
    output logic [PRE_W-1:0] last_o
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    pre_state_e       state_q, state_d;
    logic [PRE_W-1:0] cnt_q, cnt_d;
    logic [PRE_W-1:0] last_q, last_d;
    logic [PRE_W-1:0] code_last;

    // code 0 -> full range, code 1 clamped to a ratio of 2, else code-1
    always_comb begin
        if (code_i == '0)
            code_last = '1;
        else if (code_i == ONE)
            code_last = ONE;
        else
            code_last = code_i - ONE;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        last_d  = last_q;
        unique case (state_q)
            ST_COUNT: begin
                cnt_d = cnt_q + ONE;
                if (cnt_q == last_q - ONE)
                    state_d = ST_LAST;       // COUNT_TO_LAST
            end
            ST_LAST: begin
                cnt_d   = '0;
                last_d  = code_last;          // capture only at the wrap
                state_d = ST_COUNT;           // LAST_TO_COUNT
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_COUNT;              // ANY_TO_COUNT
            cnt_q   <= '0;
            last_q  <= code_last;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        wrap_o = (state_q == ST_LAST);
        cnt_o  = cnt_q;
        last_o = last_q;
    end
endmodule

// File: rtl/dpd_post_counter.sv
module dpd_post_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [CNT_W-1:0] nxt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_comb nxt_o = adv_i ? cnt_q + CNT_W'(1) : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt_o;
    end
endmodule

// File: rtl/dpd_phase_out.sv
module dpd_phase_out #(
    parameter int SEL_W         = 2,
    parameter int CNT_W         = 4,
    parameter int BIT_OFS       = 0,
    parameter bit PULSE_AT_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             out_p_o,
    output logic             out_n_o
);
    localparam int IDX_W = $clog2(CNT_W);

    logic [IDX_W-1:0] idx;
    logic             lvl_d;
    logic             p_q, n_q;

    always_comb idx = IDX_W'(int'(sel_i) + BIT_OFS);

    generate
        if (PULSE_AT_ZERO) begin : g_pulse
            always_comb begin
                if (sel_i == '0) lvl_d = wrap_i;
                else             lvl_d = cnt_nxt_i[idx];
            end
        end else begin : g_square
            always_comb lvl_d = cnt_nxt_i[idx];
        end
    endgenerate

    // true and complement kept in separate registers
    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= 1'b0;
            n_q <= 1'b1;
        end else begin
            p_q <= lvl_d;
            n_q <= ~lvl_d;
        end
    end

    always_comb begin
        out_p_o = p_q;
        out_n_o = n_q;
    end
endmodule

// File: rtl/dual_phase_divider.sv
module dual_phase_divider
    import dpd_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [SEL_W-1:0] ph1_code,
    input  logic [SEL_W-1:0] ph2_code,
    output logic             ph1_o,
    output logic             ph1_n_o,
    output logic             ph2_o,
    output logic             ph2_n_o,
    output logic             thru_o
);
    localparam int CNT_W = 2 ** SEL_W;

    logic             pre_wrap;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_last;
    logic [CNT_W-1:0] pc_nxt;
    logic [SEL_W-1:0] sel1_q, sel2_q;
    logic [SEL_W-1:0] sel1_eff, sel2_eff;

    dpd_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .code_i (pre_code),
        .wrap_o (pre_wrap),
        .cnt_o  (pre_cnt),
        .last_o (pre_last)
    );

    dpd_post_counter #(.CNT_W(CNT_W)) u_post (
        .clk   (clk),
        .rst   (rst),
        .adv_i (pre_wrap),
        .nxt_o (pc_nxt)
    );

    // selection in force from the next edge on
    always_comb begin
        sel1_eff = pre_wrap ? ph1_code : sel1_q;
        sel2_eff = pre_wrap ? ph2_code : sel2_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel1_q <= ph1_code;
            sel2_q <= ph2_code;
        end else begin
            sel1_q <= sel1_eff;
            sel2_q <= sel2_eff;
        end
    end

    dpd_phase_out #(
        .SEL_W(SEL_W), .CNT_W(CNT_W), .BIT_OFS(-1), .PULSE_AT_ZERO(1'b1)
    ) u_ph1 (
        .clk       (clk),
        .rst       (rst),
        .wrap_i    (pre_wrap),
        .sel_i     (sel1_eff),
        .cnt_nxt_i (pc_nxt),
        .out_p_o   (ph1_o),
        .out_n_o   (ph1_n_o)
    );

    dpd_phase_out #(
        .SEL_W(SEL_W), .CNT_W(CNT_W), .BIT_OFS(0), .PULSE_AT_ZERO(1'b0)
    ) u_ph2 (
        .clk       (clk),
        .rst       (rst),
        .wrap_i    (pre_wrap),
        .sel_i     (sel2_eff),
        .cnt_nxt_i (pc_nxt),
        .out_p_o   (ph2_o),
        .out_n_o   (ph2_n_o)
    );

    always_comb thru_o = clk;
endmodule

// File: rtl/dual_phase_divider_chk.sv
module dual_phase_divider_chk #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ph1,
    input logic             ph1_n,
    input logic             ph2,
    input logic             ph2_n,
    input logic             wrap,
    input logic [SEL_W-1:0] sel1,
    input logic [PRE_W-1:0] cnt,
    input logic [PRE_W-1:0] last
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);                                               // R1
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (ph1 && sel1 == '0) |=> !ph1);                              // R3
    AST_CMPL_PAIR: assert property (@(posedge clk) disable iff (rst)
        (ph1_n == !ph1) && (ph2_n == !ph2));                        // R6
    AST_EDGE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ph2) || (!$stable(ph1) && sel1 != '0)) |-> $past(wrap)); // R7
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!ph1 && !ph2 && ph1_n && ph2_n));                  // R8
endmodule

bind dual_phase_divider dual_phase_divider_chk #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ph1   (ph1_o),
    .ph1_n (ph1_n_o),
    .ph2   (ph2_o),
    .ph2_n (ph2_n_o),
    .wrap  (pre_wrap),
    .sel1  (sel1_q),
    .cnt   (pre_cnt),
    .last  (pre_last)
);

// File: tb/dual_phase_divider_bench.sv
`timescale 1ns/1ps
module dual_phase_divider_bench;
    typedef struct {
        int    ph;
        int    per;
        int    hi;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pre_code = 8'd2;
    logic [1:0] ph1_code = 2'd0;
    logic [1:0] ph2_code = 2'd0;
    logic       ph1_o, ph1_n_o, ph2_o, ph2_n_o, thru_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    dual_phase_divider u_dual_phase_divider (
        .clk(clk), .rst(rst), .pre_code(pre_code), .ph1_code(ph1_code),
        .ph2_code(ph2_code), .ph1_o(ph1_o), .ph1_n_o(ph1_n_o),
        .ph2_o(ph2_o), .ph2_n_o(ph2_n_o), .thru_o(thru_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit sample(input int ph, inout bit cmp_ok);
        if (ph == 1) begin
            if (ph1_n_o == ph1_o) cmp_ok = 1'b0;
            return ph1_o;
        end
        if (ph2_n_o == ph2_o) cmp_ok = 1'b0;
        return ph2_o;
    endfunction

    task automatic measure(input int ph, output int per, output int hi, output bit cmp_ok);
        bit v;
        cmp_ok = 1'b1;
        do begin @(negedge clk); v = sample(ph, cmp_ok); end while (v);
        do begin @(negedge clk); v = sample(ph, cmp_ok); end while (!v);
        per = 0; hi = 0;
        while (v)  begin hi++; per++; @(negedge clk); v = sample(ph, cmp_ok); end
        while (!v) begin per++; @(negedge clk); v = sample(ph, cmp_ok); end
    endtask

    // monitor: pops expected items and compares them with measurements
    initial begin
        exp_t it;
        int   per, hi;
        bit   cok;
        forever begin
            wait (exp_q.size() > 0);
            it = exp_q[0];
            measure(it.ph, per, hi, cok);
            check(per == it.per, {it.tag, " period"}, per, it.per);
            check(hi == it.hi, {it.tag, " high time R5"}, hi, it.hi);
            check(cok, "R6 complement", int'(cok), 1);
            void'(exp_q.pop_front());
        end
    end

    function automatic int n_of(input int k);
        if (k == 0) return 256;
        if (k == 1) return 2;
        return k;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // driver: applies a setting and pushes the expected shapes
    task automatic run_cfg(input int pre, input int c1, input int c2, input string tag);
        exp_t e;
        int   n;
        pre_code = 8'(pre); ph1_code = 2'(c1); ph2_code = 2'(c2);
        do_reset();
        n = n_of(pre);
        e.ph = 1; e.per = n * (1 << c1); e.hi = (c1 == 0) ? 1 : e.per / 2;
        e.tag = (c1 == 0) ? {tag, " R2 R3 ph1"} : {tag, " R2 ph1"};
        exp_q.push_back(e);
        e.ph = 2; e.per = n * (2 << c2); e.hi = e.per / 2; e.tag = {tag, " R4 ph2"};
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic next_pulse(output int d);
        d = 0;
        do begin @(negedge clk); d++; end while (!ph1_o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d1, d2, same;
        // R8 reset state
        repeat (2) @(negedge clk);
        check(!ph1_o && !ph2_o && ph1_n_o && ph2_n_o, "R8 outputs in reset",
              {ph1_o, ph2_o, ph1_n_o, ph2_n_o}, 4'b0011);
        rst = 1'b0;
        @(negedge clk);
        check(!ph1_o && !ph2_o && ph1_n_o && ph2_n_o, "R8 first cycle after reset",
              {ph1_o, ph2_o, ph1_n_o, ph2_n_o}, 4'b0011);
        // R10 pass-through
        @(posedge clk); #1;
        check(thru_o == 1'b1, "R10 thru high", int'(thru_o), 1);
        @(negedge clk); #1;
        check(thru_o == 1'b0, "R10 thru low", int'(thru_o), 0);

        run_cfg(2,   0, 0, "n2");
        run_cfg(2,   1, 1, "n2");
        run_cfg(3,   2, 3, "n3 odd");
        run_cfg(7,   3, 2, "n7 odd");
        run_cfg(5,   0, 1, "n5");
        run_cfg(255, 1, 0, "n255");
        run_cfg(1,   0, 3, "R1 code1");
        run_cfg(0,   3, 3, "R1 code0");

        // R7: ph1 code k+1 and ph2 code k must match every cycle
        pre_code = 8'd3; ph1_code = 2'd2; ph2_code = 2'd1;
        do_reset();
        same = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ph1_o !== ph2_o) same = 0;
        end
        check(same == 1, "R7 phases aligned", same, 1);

        // R9: code change mid-cycle applies from the next cycle
        pre_code = 8'd10; ph1_code = 2'd0; ph2_code = 2'd0;
        do_reset();
        next_pulse(d1);
        pre_code = 8'd3;
        next_pulse(d1);
        next_pulse(d2);
        check(d1 == 10, "R9 old length kept", d1, 10);
        check(d2 == 3, "R9 new length applied", d2, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule